// File: doc/BRIEF.md
# Vector-Prefix Program Counter and Element Step Sequencer

This block owns the program counter of a 64-bit core whose instructions may be preceded by a 32-bit vector prefix word. It inspects the fetched word, decides whether it is a prefix, and gives the address of the suffix word that follows. It also computes the address of the next instruction, which is 4 bytes on for a plain instruction and 8 bytes on for a prefixed pair.

When a prefixed instruction writes at least one vector destination, the block does not advance the PC. It keeps the PC where it is and walks an internal 7-bit element step from zero up to the loop limit minus one. On each pass it re-issues the same instruction and offsets the register numbers of the vector operands by the step. The execute stage reports each finished pass with a one-cycle strobe, and the PC and step registers change only on that strobe. A trap request sends the PC to a fixed vector and abandons any loop that is running.

Top module: `vstep_seq`

## Requirements
- R1: `is_prefixed` is 1 exactly when fetch word bits [31:26] equal 6'b000001 and bits [24] and [22] are both 1. Bit numbering here is LSB = 0, so these are major-opcode bits 0..5 and word bits 7 and 9 when counted MSB-first.
- R2: On an `exec_done` pulse with no trap and a word that is not a prefix, `cur_pc` becomes `cur_pc + 4` and `step` stays 0. This holds even when destination vector flags are set.
- R3: On an `exec_done` pulse for a prefixed word whose destinations are all scalar, `cur_pc` becomes `cur_pc + 8` and `step` is 0.
- R4: `suffix_addr` always equals `cur_pc + 4`, using 64-bit wrap-around arithmetic.
- R5: On an `exec_done` pulse for a prefixed word with at least one vector destination, when `step` differs from the limit minus one and the limit is non-zero, `step` increments by 1 and `cur_pc` is unchanged.
- R6: On an `exec_done` pulse where `step` equals the limit minus one, `step` clears to 0 and `cur_pc` becomes `cur_pc + 8`.
- R7: The loop limit is the smaller of `vec_len` and `max_vec_len`. A limit of 0 finishes the instruction in one pass, with `step` staying at 0.
- R8: On an `exec_done` pulse with `trap_req` high, `cur_pc` becomes 0x700 and `step` becomes 0, even in the middle of a loop.
- R9: For a prefixed word, an operand with its vector flag set presents base + `step` modulo 128. A scalar operand, or any operand of a word that is not a prefix, presents its base number unchanged.
- R10: Without `exec_done`, `cur_pc` and `step` hold their values.
- R11: A synchronous reset (`rst_n` low at a clock edge) loads `cur_pc` with the INIT_PC parameter (default 0x1000) and clears `step`.
- R12: `next_pc` shows the value that `cur_pc` takes on the next `exec_done` pulse given the present inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_word | input | 32 | Word fetched at `cur_pc` |
| exec_done | input | 1 | One-cycle strobe: one pass of the current instruction is finished |
| trap_req | input | 1 | Privilege or illegal-instruction trap request for the finished pass |
| vec_len | input | 7 | Vector length |
| max_vec_len | input | 7 | Maximum vector length |
| src_base | input | 21 | Three 7-bit source register numbers; operand i at [i*7 +: 7] |
| src_vec | input | 3 | Vector flag for each source |
| dst_base | input | 14 | Two 7-bit destination register numbers; operand i at [i*7 +: 7] |
| dst_vec | input | 2 | Vector flag for each destination |
| cur_pc | output | 64 | Current instruction address |
| next_pc | output | 64 | Address to be taken on the next `exec_done` |
| suffix_addr | output | 64 | Address of the suffix word |
| is_prefixed | output | 1 | Fetched word is a vector prefix |
| step | output | 7 | Current element step |
| src_reg | output | 21 | Adjusted source register numbers |
| dst_reg | output | 14 | Adjusted destination register numbers |

## Verification
The hardest case to reach is a trap or a change of operand state in the middle of an element loop. For that, the PC must be held with a non-zero step at the moment the trap or change arrives. The bench first issues a prefixed word with a vector destination and a loop limit above two. It pulses `exec_done` enough times to place `step` inside the loop, and only then raises `trap_req`, swaps the fetched word for a plain one, or sets a base register of 127. It then observes the redirect, the gating of the offset, and the wrap to 0.

// File: rtl/vstep_pkg.sv
// Package: shared widths and constants for the vector step sequencer.
// Assumes a 64-bit address space and 7-bit register and step fields.
package vstep_pkg;
    localparam int XLEN   = 64;
    localparam int WORD_W = 32;
    localparam int REG_W  = 7;
    localparam int STEP_W = 7;

    // Prefix identification fields (LSB = 0 numbering)
    localparam logic [5:0] PFX_MAJOR = 6'b000001;
    localparam int PFX_MAJ_HI = 31;
    localparam int PFX_MAJ_LO = 26;
    localparam int PFX_ID_A   = 24;
    localparam int PFX_ID_B   = 22;

    // Byte increments for plain and prefixed instructions
    localparam logic [XLEN-1:0] STRIDE_PLAIN = 64'd4;
    localparam logic [XLEN-1:0] STRIDE_PFX   = 64'd8;

    typedef enum logic [1:0] {
        ACT_ADVANCE = 2'd0,
        ACT_REPEAT  = 2'd1,
        ACT_TRAP    = 2'd2
    } step_act_e;
endpackage

// File: rtl/vstep_prefix_detect.sv
// Module: vstep_prefix_detect
// Decides whether a fetched word is a vector prefix, purely combinationally.
// Assumes the word is presented with bit 31 as the most significant bit.
module vstep_prefix_detect
    import vstep_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              is_pfx
);
    logic major_ok;
    logic ids_ok;

    // Compare the major opcode and the two identifying bits
    always_comb begin
        major_ok = (word[PFX_MAJ_HI:PFX_MAJ_LO] == PFX_MAJOR);
        ids_ok   = word[PFX_ID_A] & word[PFX_ID_B];
        is_pfx   = major_ok & ids_ok;
    end
endmodule

// File: rtl/vstep_reg_offset.sv
// Module: vstep_reg_offset
// Adds the element step to each vector-flagged register number.
// Assumes a flat bus of N fields, each REG_W wide, and sums that wrap modulo 2**REG_W.
module vstep_reg_offset #(
    parameter int N      = 3,
    parameter int REG_W  = 7,
    parameter int STEP_W = 7
) (
    input  logic [N*REG_W-1:0] base,
    input  logic [N-1:0]       vec,
    input  logic               en,
    input  logic [STEP_W-1:0]  step,
    output logic [N*REG_W-1:0] adj
);
    localparam int SUM_W = (REG_W > STEP_W) ? REG_W : STEP_W;

    for (genvar i = 0; i < N; i++) begin : g_opnd
        logic [SUM_W-1:0] sum;
        // Offset a vector operand; pass a scalar operand through
        always_comb begin
            sum = SUM_W'(base[i*REG_W +: REG_W]) + SUM_W'(step);
            if (en && vec[i])
                adj[i*REG_W +: REG_W] = sum[REG_W-1:0];
            else
                adj[i*REG_W +: REG_W] = base[i*REG_W +: REG_W];
        end
    end
endmodule

// File: rtl/vstep_step_ctrl.sv
// Module: vstep_step_ctrl
// Holds the PC and the element step and picks advance, repeat or trap on each done strobe.
// Assumes exec_done is a one-cycle pulse and that the reset is synchronous and active-low.
module vstep_step_ctrl
    import vstep_pkg::*;
#(
    parameter logic [XLEN-1:0] INIT_PC  = 64'h1000,
    parameter logic [XLEN-1:0] TRAP_VEC = 64'h700
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_done,
    input  logic              trap_req,
    input  logic              is_pfx,
    input  logic              any_dst_vec,
    input  logic [STEP_W-1:0] limit,
    output logic [XLEN-1:0]   pc_q,
    output logic [STEP_W-1:0] step_q,
    output logic [XLEN-1:0]   pc_nxt
);
    step_act_e         act;
    logic              at_last;
    logic [XLEN-1:0]   stride;
    logic [STEP_W-1:0] step_nxt;

    // Choose the action for the pass that is finishing
    always_comb begin
        at_last = (limit == '0) || (step_q == limit - STEP_W'(1));
        if (trap_req)
            act = ACT_TRAP;
        else if (is_pfx && any_dst_vec && !at_last)
            act = ACT_REPEAT;
        else
            act = ACT_ADVANCE;
    end

    // Form the next PC and next step for the chosen action
    always_comb begin
        stride = is_pfx ? STRIDE_PFX : STRIDE_PLAIN;
        unique case (act)
            ACT_TRAP: begin
                pc_nxt   = TRAP_VEC;
                step_nxt = '0;
            end
            ACT_REPEAT: begin
                pc_nxt   = pc_q;
                step_nxt = step_q + STEP_W'(1);
            end
            default: begin
                pc_nxt   = pc_q + stride;
                step_nxt = '0;
            end
        endcase
    end

    // Commit PC and step on the done strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= INIT_PC;
            step_q <= '0;
        end else if (exec_done) begin
            pc_q   <= pc_nxt;
            step_q <= step_nxt;
        end
    end
endmodule

// File: rtl/vstep_seq.sv
// Module: vstep_seq (top)
// Program counter and element step sequencer for instructions that may carry a vector prefix.
// Assumes operand base numbers and vector flags are stable while a loop runs.
module vstep_seq
    import vstep_pkg::*;
#(
    parameter int              NUM_SRC  = 3,
    parameter int              NUM_DST  = 2,
    parameter logic [63:0]     INIT_PC  = 64'h1000,
    parameter logic [63:0]     TRAP_VEC = 64'h700
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [31:0]              fetch_word,
    input  logic                     exec_done,
    input  logic                     trap_req,
    input  logic [6:0]               vec_len,
    input  logic [6:0]               max_vec_len,
    input  logic [NUM_SRC*7-1:0]     src_base,
    input  logic [NUM_SRC-1:0]       src_vec,
    input  logic [NUM_DST*7-1:0]     dst_base,
    input  logic [NUM_DST-1:0]       dst_vec,
    output logic [63:0]              cur_pc,
    output logic [63:0]              next_pc,
    output logic [63:0]              suffix_addr,
    output logic                     is_prefixed,
    output logic [6:0]               step,
    output logic [NUM_SRC*7-1:0]     src_reg,
    output logic [NUM_DST*7-1:0]     dst_reg
);
    logic              pfx;
    logic              any_dst_vec;
    logic [STEP_W-1:0] limit;
    logic [XLEN-1:0]   pc_q;
    logic [STEP_W-1:0] step_q;
    logic [XLEN-1:0]   pc_nxt;

    vstep_prefix_detect u_pfx (
        .word   (fetch_word),
        .is_pfx (pfx)
    );

    // Loop limit is the smaller of the length and its maximum
    always_comb begin
        limit       = (vec_len < max_vec_len) ? vec_len : max_vec_len;
        any_dst_vec = |dst_vec;
    end

    vstep_step_ctrl #(
        .INIT_PC  (INIT_PC),
        .TRAP_VEC (TRAP_VEC)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .exec_done   (exec_done),
        .trap_req    (trap_req),
        .is_pfx      (pfx),
        .any_dst_vec (any_dst_vec),
        .limit       (limit),
        .pc_q        (pc_q),
        .step_q      (step_q),
        .pc_nxt      (pc_nxt)
    );

    vstep_reg_offset #(
        .N(NUM_SRC), .REG_W(REG_W), .STEP_W(STEP_W)
    ) u_src_off (
        .base (src_base),
        .vec  (src_vec),
        .en   (pfx),
        .step (step_q),
        .adj  (src_reg)
    );

    vstep_reg_offset #(
        .N(NUM_DST), .REG_W(REG_W), .STEP_W(STEP_W)
    ) u_dst_off (
        .base (dst_base),
        .vec  (dst_vec),
        .en   (pfx),
        .step (step_q),
        .adj  (dst_reg)
    );

    // Drive the visible address outputs
    always_comb begin
        cur_pc      = pc_q;
        next_pc     = pc_nxt;
        suffix_addr = pc_q + STRIDE_PLAIN;
        is_prefixed = pfx;
        step        = step_q;
    end
endmodule

// File: rtl/vstep_seq_chk.sv
// Module: vstep_seq_chk
// Checker with temporal properties on the sequencer ports, bound into vstep_seq.
// Assumes the same parameters as the top module.
module vstep_seq_chk #(
    parameter int          NUM_DST  = 2,
    parameter logic [63:0] INIT_PC  = 64'h1000,
    parameter logic [63:0] TRAP_VEC = 64'h700
) (
    input logic               clk,
    input logic               rst_n,
    input logic               exec_done,
    input logic               trap_req,
    input logic               is_prefixed,
    input logic [NUM_DST-1:0] dst_vec,
    input logic [6:0]         vec_len,
    input logic [6:0]         max_vec_len,
    input logic [63:0]        cur_pc,
    input logic [63:0]        next_pc,
    input logic [6:0]         step
);
    logic [6:0] lim;
    logic       loop_go;

    // Independent view of the loop limit and the repeat condition
    always_comb begin
        lim     = (max_vec_len < vec_len) ? max_vec_len : vec_len;
        loop_go = is_prefixed && (dst_vec != '0) && (lim != 7'd0) && (step != lim - 7'd1);
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(!rst_n) |-> (cur_pc == INIT_PC && step == 7'd0)); // R11

    AST_PLAIN_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_done && !trap_req && !is_prefixed) |=> (cur_pc == $past(cur_pc) + 64'd4 && step == 7'd0)); // R2

    AST_LOOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_done && !trap_req && loop_go) |=> (cur_pc == $past(cur_pc) && step == $past(step) + 7'd1)); // R5

    AST_LOOP_END: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_done && !trap_req && is_prefixed && !loop_go) |=> (cur_pc == $past(cur_pc) + 64'd8 && step == 7'd0)); // R6

    AST_TRAP_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_done && trap_req) |=> (cur_pc == TRAP_VEC && step == 7'd0)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_done |=> ($stable(cur_pc) && $stable(step))); // R10

    AST_NEXT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        exec_done |=> (cur_pc == $past(next_pc))); // R12

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_done && !trap_req && lim == 7'd0) |=> (step == 7'd0)); // R7
endmodule

bind vstep_seq vstep_seq_chk #(
    .NUM_DST  (NUM_DST),
    .INIT_PC  (INIT_PC),
    .TRAP_VEC (TRAP_VEC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .exec_done   (exec_done),
    .trap_req    (trap_req),
    .is_prefixed (is_prefixed),
    .dst_vec     (dst_vec),
    .vec_len     (vec_len),
    .max_vec_len (max_vec_len),
    .cur_pc      (cur_pc),
    .next_pc     (next_pc),
    .step        (step)
);

// File: tb/sim_vstep_seq.sv
// Directed bench for vstep_seq: one task per scenario, each checking its own results.
module sim_vstep_seq;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] W_PFX   = 32'h0540_0000;
    localparam logic [31:0] W_PLAIN = 32'h3800_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_word = W_PLAIN;
    logic        exec_done = 1'b0;
    logic        trap_req = 1'b0;
    logic [6:0]  vec_len = 7'd0;
    logic [6:0]  max_vec_len = 7'd0;
    logic [20:0] src_base = '0;
    logic [2:0]  src_vec = '0;
    logic [13:0] dst_base = '0;
    logic [1:0]  dst_vec = '0;
    logic [63:0] cur_pc, next_pc, suffix_addr;
    logic        is_prefixed;
    logic [6:0]  step;
    logic [20:0] src_reg;
    logic [13:0] dst_reg;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] exp_pc;

    always #(CLK_PERIOD/2) clk = ~clk;

    vstep_seq u0 (
        .clk(clk), .rst_n(rst_n), .fetch_word(fetch_word), .exec_done(exec_done),
        .trap_req(trap_req), .vec_len(vec_len), .max_vec_len(max_vec_len),
        .src_base(src_base), .src_vec(src_vec), .dst_base(dst_base), .dst_vec(dst_vec),
        .cur_pc(cur_pc), .next_pc(next_pc), .suffix_addr(suffix_addr),
        .is_prefixed(is_prefixed), .step(step), .src_reg(src_reg), .dst_reg(dst_reg)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One exec_done pulse; returns at the next falling edge with registers updated
    task automatic pulse_done();
        exec_done = 1'b1;
        @(negedge clk);
        exec_done = 1'b0;
    endtask

    task automatic t_reset();
        check("R11 pc", cur_pc, 64'h1000);
        check("R11 step", {57'd0, step}, 64'd0);
        exp_pc = 64'h1000;
    endtask

    task automatic t_prefix_detect();
        fetch_word = W_PFX;        #1 check("R1 prefix", {63'd0, is_prefixed}, 64'd1);
        fetch_word = 32'h0500_0000; #1 check("R1 bit22 clear", {63'd0, is_prefixed}, 64'd0);
        fetch_word = 32'h0440_0000; #1 check("R1 bit24 clear", {63'd0, is_prefixed}, 64'd0);
        fetch_word = 32'h4540_0000; #1 check("R1 major", {63'd0, is_prefixed}, 64'd0);
        fetch_word = 32'h057F_FFFF; #1 check("R1 other bits", {63'd0, is_prefixed}, 64'd1);
        @(negedge clk);
    endtask

    task automatic t_plain();
        fetch_word = W_PLAIN; dst_vec = 2'b11; vec_len = 7'd4; max_vec_len = 7'd8;
        #1 check("R12 next plain", next_pc, exp_pc + 4);
        @(negedge clk);
        pulse_done();
        exp_pc += 4;
        check("R2 pc", cur_pc, exp_pc);
        check("R2 step", {57'd0, step}, 64'd0);
        dst_vec = 2'b00;
    endtask

    task automatic t_pfx_scalar();
        fetch_word = W_PFX; dst_vec = 2'b00; vec_len = 7'd4; max_vec_len = 7'd8;
        #1 check("R4 suffix", suffix_addr, exp_pc + 4);
        @(negedge clk);
        pulse_done();
        exp_pc += 8;
        check("R3 pc", cur_pc, exp_pc);
        check("R3 step", {57'd0, step}, 64'd0);
    endtask

    task automatic t_loop();
        fetch_word = W_PFX; dst_vec = 2'b01; vec_len = 7'd3; max_vec_len = 7'd8;
        src_vec = 3'b001; src_base = {7'd20, 7'd9, 7'd5}; dst_base = {7'd30, 7'd40};
        #1 check("R12 next hold", next_pc, exp_pc);
        @(negedge clk);
        pulse_done();
        check("R5 pc held", cur_pc, exp_pc);
        check("R5 step1", {57'd0, step}, 64'd1);
        check("R9 vec src", {57'd0, src_reg[6:0]}, 64'd6);
        check("R9 scalar src", {57'd0, src_reg[13:7]}, 64'd9);
        check("R9 vec dst", {57'd0, dst_reg[6:0]}, 64'd41);
        check("R9 scalar dst", {57'd0, dst_reg[13:7]}, 64'd30);
        fetch_word = W_PLAIN; #1
        check("R9 plain no offset", {57'd0, src_reg[6:0]}, 64'd5);
        fetch_word = W_PFX;
        repeat (3) @(negedge clk);
        check("R10 pc idle", cur_pc, exp_pc);
        check("R10 step idle", {57'd0, step}, 64'd1);
        pulse_done();
        check("R5 step2", {57'd0, step}, 64'd2);
        check("R5 pc held2", cur_pc, exp_pc);
        pulse_done();
        exp_pc += 8;
        check("R6 pc", cur_pc, exp_pc);
        check("R6 step", {57'd0, step}, 64'd0);
    endtask

    task automatic t_clamp();
        fetch_word = W_PFX; dst_vec = 2'b10; vec_len = 7'd10; max_vec_len = 7'd2;
        pulse_done();
        check("R7 clamp step1", {57'd0, step}, 64'd1);
        pulse_done();
        exp_pc += 8;
        check("R7 clamp end pc", cur_pc, exp_pc);
        check("R7 clamp end step", {57'd0, step}, 64'd0);
        vec_len = 7'd0; max_vec_len = 7'd8;
        pulse_done();
        exp_pc += 8;
        check("R7 zero pc", cur_pc, exp_pc);
        check("R7 zero step", {57'd0, step}, 64'd0);
    endtask

    task automatic t_wrap();
        fetch_word = W_PFX; dst_vec = 2'b01; vec_len = 7'd3; max_vec_len = 7'd3;
        dst_base = {7'd3, 7'd127};
        pulse_done();
        check("R9 wrap", {57'd0, dst_reg[6:0]}, 64'd0);
        pulse_done();
        pulse_done();
        exp_pc += 8;
        check("R6 wrap end", cur_pc, exp_pc);
    endtask

    task automatic t_trap();
        fetch_word = W_PFX; dst_vec = 2'b01; vec_len = 7'd5; max_vec_len = 7'd8;
        pulse_done();
        check("R5 pre-trap step", {57'd0, step}, 64'd1);
        trap_req = 1'b1;
        #1 check("R12 next trap", next_pc, 64'h700);
        pulse_done();
        trap_req = 1'b0;
        exp_pc = 64'h700;
        check("R8 pc", cur_pc, exp_pc);
        check("R8 step", {57'd0, step}, 64'd0);
        fetch_word = W_PLAIN;
        pulse_done();
        exp_pc += 4;
        check("R2 after trap", cur_pc, exp_pc);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_prefix_detect();
        t_plain();
        t_pfx_scalar();
        t_loop();
        t_clamp();
        t_wrap();
        t_trap();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule